// File: doc/BRIEF.md
# External Clock Failure Monitor with Automatic Switchover

This block watches an external main clock from a free-running internal reference clock. It samples the external clock into the reference domain and counts its rising edges over fixed windows. When a window ends with no edges, the block records that the external clock has stopped. Depending on how software has configured it, the block can then raise an interrupt and move the system clock over to the internal oscillator without any help from software.

Software controls and observes the block through one 8-bit register on a simple synchronous write strobe, with a combinational read path. Every write is dropped unless a separate write-protect enable input is high during the write cycle. The block drives three outputs for the rest of the chip. The first selects the internal oscillator as system clock. The second is the stop-status flag. The third is a one-cycle interrupt request. A fourth output keeps the low-speed internal oscillator running whenever the internal clock is selected.

Top module: `clkmon_top`

## Requirements
- R1: Register bits are: bit 0 detection enable, bit 1 interrupt enable, bit 2 clock select (0 = external, 1 = internal), bit 3 stop status (1 = external clock stopped). Bits 7..4 always read 0. After reset all bits are 0 and every output is 0 unless the slow-oscillator request is high.
- R2: A write updates the register only when `regWr` and `protectEn` are both 1 in the same cycle. Otherwise the register is unchanged.
- R3: Writes to bits 7..4 and to the stop-status bit 3 have no effect. Bit 3 is changed by hardware only.
- R4: With detection enabled, a 16-reference-cycle window with no external rising edge sets the stop-status bit.
- R5: With detection enabled, a window with at least 4 edges clears the stop-status bit. A window with 1 to 3 edges leaves it unchanged.
- R6: While detection enable is 0, the stop-status bit reads 0 whatever the external clock does.
- R7: When stop is detected while both enable bits are 1, hardware sets the clock-select bit to 1.
- R8: While the stop-status bit is 1, a software write of 0 to clock select is ignored. A write of 1 is still accepted.
- R9: `irqPulse` is high for exactly one cycle on each 0-to-1 transition of the stop-status bit that occurs while both enable bits are 1. It is never high otherwise.
- R10: `slowOscOn` is 1 whenever clock select is 1. Otherwise it follows `slowOscReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClk | input | 1 | External main clock being watched (asynchronous) |
| protectEn | input | 1 | Write-protect enable; writes are accepted only while high |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| slowOscReq | input | 1 | Request from elsewhere to keep the low-speed oscillator on |
| clkSelInt | output | 1 | System clock select, 1 = internal oscillator |
| stopFlag | output | 1 | External clock stopped |
| irqPulse | output | 1 | One-cycle stop interrupt request |
| slowOscOn | output | 1 | Low-speed oscillator enable |

## Verification
A wrong edge count or a wrong window decision shows up at the ports in `stopFlag` and in bit 3 of the read data. It appears within about two windows (roughly 35 reference cycles) of a change on the external clock. If the switchover or lock-out logic goes wrong, `clkSelInt` moves when it should hold, or holds when it should move. The slow-oscillator output then follows it on the same cycle. Stepping the external clock between stopped, slow (2 edges per window) and fast patterns makes each such error visible at a read-back within a few windows. A bad interrupt condition shows up as a wrong pulse count over the same span.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  // Register bit positions (software-visible layout)
  localparam int unsigned BIT_DET_EN = 0;
  localparam int unsigned BIT_IRQ_EN = 1;
  localparam int unsigned BIT_SEL    = 2;
  localparam int unsigned BIT_STOP   = 3;
  localparam int unsigned REG_W      = 8;

  // Strobes from the window timer to the edge datapath
  typedef struct packed {
    logic winEnd;
  } winStrobe_t;

  // Per-window decision from the datapath
  typedef struct packed {
    logic valid;
    logic none;
    logic enough;
  } winVerdict_t;

endpackage

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
  import clkmon_pkg::*;
#(
  parameter int unsigned WINDOW = 16
) (
  input  logic       clk,
  input  logic       rstN,
  output winStrobe_t strobe
);
  localparam int unsigned WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

  logic [WIN_W-1:0] winCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (winCnt == WIN_LAST) begin
      winCnt <= '0;
    end else begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.winEnd = (winCnt == WIN_LAST);
  end

  // R4: window end strobe never on two consecutive cycles
  a_r4_window_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strobe.winEnd |=> !strobe.winEnd);

endmodule

// File: rtl/clkmon_dp.sv
module clkmon_dp
  import clkmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned WINDOW        = 16,
  parameter int unsigned RESTART_EDGES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extClk,
  input  winStrobe_t  strobe,
  output winVerdict_t verdict
);
  localparam int unsigned CNT_W = $clog2(WINDOW + 2);

  // syncQ[SYNC_STAGES-1] is the synchronised level, syncQ[SYNC_STAGES] its delayed copy
  logic [SYNC_STAGES:0] syncQ;
  logic                 edgePulse;
  logic [CNT_W-1:0]     edgeCnt;
  logic [CNT_W-1:0]     edgeTotal;

  for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= extClk;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign edgePulse = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
  assign edgeTotal = edgeCnt + CNT_W'(edgePulse);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt <= '0;
      verdict <= '0;
    end else if (strobe.winEnd) begin
      edgeCnt        <= '0;
      verdict.valid  <= 1'b1;
      verdict.none   <= (edgeTotal == '0);
      verdict.enough <= (edgeTotal >= CNT_W'(RESTART_EDGES));
    end else begin
      edgeCnt       <= edgeTotal;
      verdict.valid <= 1'b0;
    end
  end

  // R4/R5: a window cannot be both empty and above the restart threshold
  a_r5_verdict_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    verdict.valid |-> !(verdict.none && verdict.enough));

  // R4: one verdict per window
  a_r4_verdict_single: assert property (@(posedge clk) disable iff (!rstN)
    verdict.valid |=> !verdict.valid);

endmodule

// File: rtl/clkmon_regs.sv
module clkmon_regs
  import clkmon_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             protectEn,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWrData,
  input  winVerdict_t      verdict,
  output logic [REG_W-1:0] regRdData,
  output logic             selQ,
  output logic             stopQ,
  output logic             irqQ
);
  logic detEnQ, irqEnQ;
  logic detEnN, irqEnN, selN, stopN, irqN;
  logic wrOk, hwSwitch;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:BIT_STOP];

  always_comb begin
    wrOk   = regWr & protectEn;
    detEnN = wrOk ? regWrData[BIT_DET_EN] : detEnQ;
    irqEnN = wrOk ? regWrData[BIT_IRQ_EN] : irqEnQ;

    // stop status: updated by window verdicts while detection is on
    stopN = stopQ;
    if (verdict.valid && detEnQ) begin
      if (verdict.none)        stopN = 1'b1;
      else if (verdict.enough) stopN = 1'b0;
    end
    if (!detEnN) stopN = 1'b0;

    // clock select: software may not return to external while stopped
    hwSwitch = verdict.valid & verdict.none & detEnQ & detEnN & irqEnN;
    selN = selQ;
    if (wrOk && (regWrData[BIT_SEL] || !stopQ)) selN = regWrData[BIT_SEL];
    if (hwSwitch) selN = 1'b1;

    irqN = stopN & ~stopQ & detEnN & irqEnN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      detEnQ <= 1'b0;
      irqEnQ <= 1'b0;
      selQ   <= 1'b0;
      stopQ  <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      detEnQ <= detEnN;
      irqEnQ <= irqEnN;
      selQ   <= selN;
      stopQ  <= stopN;
      irqQ   <= irqN;
    end
  end

  always_comb begin
    regRdData             = '0;
    regRdData[BIT_DET_EN] = detEnQ;
    regRdData[BIT_IRQ_EN] = irqEnQ;
    regRdData[BIT_SEL]    = selQ;
    regRdData[BIT_STOP]   = stopQ;
  end

  // R6: stop status never set while detection is off
  a_r6_stop_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    !detEnQ |-> !stopQ);

  // R8: internal select cannot be dropped while stopped
  a_r8_sel_locked: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ && selQ) |=> selQ);

  // R7: a stop raised with both enables set moves to the internal clock
  a_r7_auto_switch: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(stopQ) && detEnQ && irqEnQ) |-> selQ);

  // R9: interrupt is a single-cycle pulse accompanying a set stop flag
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |=> !irqQ);
  a_r9_irq_with_stop: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> stopQ);

  // R2: enable bits change only after a protected write
  a_r2_protected: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWr && protectEn) |-> ($stable(irqEnQ) && (detEnQ || $stable(detEnQ))));

endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
  import clkmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned WINDOW        = 16,
  parameter int unsigned RESTART_EDGES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extClk,
  input  logic       protectEn,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       slowOscReq,
  output logic       clkSelInt,
  output logic       stopFlag,
  output logic       irqPulse,
  output logic       slowOscOn
);
  winStrobe_t  strobe;
  winVerdict_t verdict;
  logic        selQ, stopQ, irqQ;

  clkmon_ctrl #(.WINDOW(WINDOW)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  clkmon_dp #(
    .SYNC_STAGES   (SYNC_STAGES),
    .WINDOW        (WINDOW),
    .RESTART_EDGES (RESTART_EDGES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .extClk  (extClk),
    .strobe  (strobe),
    .verdict (verdict)
  );

  clkmon_regs regs_i (
    .clk       (clk),
    .rstN      (rstN),
    .protectEn (protectEn),
    .regWr     (regWr),
    .regWrData (regWrData),
    .verdict   (verdict),
    .regRdData (regRdData),
    .selQ      (selQ),
    .stopQ     (stopQ),
    .irqQ      (irqQ)
  );

  assign clkSelInt = selQ;
  assign stopFlag  = stopQ;
  assign irqPulse  = irqQ;
  assign slowOscOn = selQ | slowOscReq;

  // R10: internal select forces the slow oscillator on
  a_r10_slow_forced: assert property (@(posedge clk) disable iff (!rstN)
    clkSelInt |-> slowOscOn);

endmodule

// File: tb/clkmon_top_tb_top.sv
`timescale 1ns/1ps
module clkmon_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extClk = 1'b0;
  logic       protectEn = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic       slowOscReq = 1'b0;
  logic [7:0] regRdData;
  logic       clkSelInt, stopFlag, irqPulse, slowOscOn;

  int compared = 0;
  int mismatched = 0;
  int irqCount = 0;
  int irqWide = 0;
  logic irqPrev = 1'b0;
  int extMode = 1;   // 0 stopped, 1 fast (8 edges/window), 2 slow (2 edges/window)
  bit done = 0;

  always #4 clk = ~clk;

  clkmon_top dut_i (
    .clk(clk), .rstN(rstN), .extClk(extClk), .protectEn(protectEn),
    .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData),
    .slowOscReq(slowOscReq), .clkSelInt(clkSelInt), .stopFlag(stopFlag),
    .irqPulse(irqPulse), .slowOscOn(slowOscOn)
  );

  // external clock pattern generator
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      phase++;
      case (extMode)
        0: extClk = 1'b0;
        1: extClk = ~extClk;
        default: if (phase % 4 == 0) extClk = ~extClk;
      endcase
    end
  end

  // interrupt pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (irqPulse) irqCount++;
      if (irqPulse && irqPrev) irqWide++;
      irqPrev = irqPulse;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic prot, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; protectEn = prot; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; protectEn = 1'b0; regWrData = '0;
  endtask

  // {prot, wr, data[7:0], mode[1:0], expRd[7:0], expIrq[1:0]}
  localparam int NVEC = 16;
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'h01, 2'd1, 8'h01, 2'd0},  // R4 enable detection, clock running
    {1'b0, 1'b0, 8'h00, 2'd0, 8'h09, 2'd0},  // R4 stop detected, no auto switch
    {1'b0, 1'b0, 8'h00, 2'd1, 8'h01, 2'd0},  // R5 restart clears stop
    {1'b1, 1'b1, 8'h03, 2'd1, 8'h03, 2'd0},  // R1 both enables
    {1'b0, 1'b0, 8'h00, 2'd0, 8'h0F, 2'd1},  // R7 R9 auto switch + irq
    {1'b0, 1'b0, 8'h00, 2'd2, 8'h0F, 2'd0},  // R5 2 edges/window keeps stop
    {1'b1, 1'b1, 8'h03, 2'd2, 8'h0F, 2'd0},  // R8 select write 0 ignored
    {1'b0, 1'b0, 8'h00, 2'd1, 8'h07, 2'd0},  // R5 clears, select stays
    {1'b1, 1'b1, 8'h03, 2'd1, 8'h03, 2'd0},  // R8 select writable after stop clears
    {1'b0, 1'b1, 8'h00, 2'd1, 8'h03, 2'd0},  // R2 unprotected write dropped
    {1'b1, 1'b1, 8'hF8, 2'd1, 8'h00, 2'd0},  // R3 reserved and bit 3 ignored
    {1'b0, 1'b0, 8'h00, 2'd0, 8'h00, 2'd0},  // R6 detection off, stop held 0
    {1'b1, 1'b1, 8'h05, 2'd0, 8'h0D, 2'd0},  // R9 stop without irq enable
    {1'b1, 1'b1, 8'h01, 2'd0, 8'h0D, 2'd0},  // R8 lock while stopped
    {1'b1, 1'b1, 8'h02, 2'd0, 8'h06, 2'd0},  // R6 disable clears stop, R8 lock
    {1'b1, 1'b1, 8'h00, 2'd1, 8'h00, 2'd0}   // R8 release to external
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset read", regRdData, 8'h00);
    check("R1 reset outputs", {clkSelInt, stopFlag, irqPulse, slowOscOn}, 0);
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    check("R1 idle after reset", regRdData, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [21:0] v;
      int irqStart;
      v = VEC[i];
      irqStart = irqCount;
      if (v[20]) regWrite(v[21], v[19:12]);
      extMode = int'(v[11:10]);
      repeat (48) @(negedge clk);
      check($sformatf("R1-vector %0d read", i), regRdData, v[9:2]);
      check($sformatf("R4 vector %0d stopFlag", i), stopFlag, v[5]);
      check($sformatf("R7 vector %0d clkSelInt", i), clkSelInt, v[4]);
      check($sformatf("R9 vector %0d irq count", i), irqCount - irqStart, v[1:0]);
    end
    check("R9 pulse width", irqWide, 0);

    // R10 slow oscillator forcing
    regWrite(1'b1, 8'h04);
    @(negedge clk);
    check("R10 forced by select", slowOscOn, 1);
    regWrite(1'b1, 8'h00);
    @(negedge clk);
    check("R10 follows request low", slowOscOn, 0);
    slowOscReq = 1'b1;
    @(negedge clk);
    check("R10 follows request high", slowOscOn, 1);
    slowOscReq = 1'b0;

    // R1 mid-run reset after a stop with switchover
    regWrite(1'b1, 8'h03);
    extMode = 0;
    repeat (48) @(negedge clk);
    check("R7 switched before reset", regRdData, 8'h0F);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset clears register", regRdData, 8'h00);
    check("R1 reset clears select", clkSelInt, 0);
    rstN = 1'b1;
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule